// File: doc/BRIEF.md
# Memory-Addressed Register Rename Cache

This block is the rename stage of a core in which architectural registers live in memory. Each operand's register index is added to a per-thread base pointer, and the sum is a memory address. That address is looked up in a small fully associative table, and each table entry stands for one physical register. The physical register file therefore acts as a hardware-managed cache of memory-resident registers. All threads share the table. Each thread contributes only its own base pointer and its thread id, which is stored next to the tag.

A rename request carries one source and one destination index and is held until it is granted. A source that misses claims an entry and asks a transfer engine to fill it. The request then waits until the fill is done. A destination always receives a fresh entry without a fill, because its old value is about to be overwritten. When the chosen entry holds a value written by a destination, the block issues a spill so that the transfer engine can write that value back.

Commit notifications release reference counts and make the newest destination mapping architectural. A branch-mispredict flush brings the speculative mappings back to the committed set. Tags keep only the low address bits, which relies on register addresses staying close together.

Top module: `regcache_rename`

## Requirements
- R1: After reset, `ren_ok`, `fill_req` and `spill_req` are low and every entry is unused, so the first allocations take entries 0, 1, 2 and so on, in that order.
- R2: The backing address of an operand is `base[tid] + index`, with the index zero-extended and the sum taken modulo 2^AW. A base pointer write becomes visible to renames in the next cycle.
- R3: When a source misses, `fill_req` rises one cycle later with `fill_addr` and `fill_phys`. It stays high with stable values until `fill_done`. `ren_ok` stays low until the cycle after `fill_done`, and it then reports the filled entry as `src_phys`.
- R4: A source hit grants without a fill. A destination never causes a fill, and it always receives an entry different from the source entry.
- R5: A lookup hits only on an entry with the same thread id and the same low TW address bits. Address bits above TW are ignored, and at most one entry matches.
- R6: An entry is a candidate for allocation when its reference count is zero, it has no pending fill and it is not a committed mapping hidden by a newer speculative one. An unused candidate is taken first, lowest index first. Otherwise the candidate with the largest age is taken, with ties going to the lowest index. Age is a saturating count of grants since the entry was last renamed. With no candidate, rename stalls.
- R7: Allocating over a valid entry last written as a destination raises `spill_req` for one cycle, one cycle after the allocation. It carries `spill_phys` and `spill_addr = {base[entry thread][AW-1:TW], tag}`. An entry that only ever held a filled source is clean and produces no spill.
- R8: `flush` makes the committed mappings the speculative ones: a committed mapping that a newer destination had hidden hits again, uncommitted destination entries become unused, and all reference counts return to zero.
- R9: A commit decrements the reference counts of its source and destination entries. It marks the destination entry committed, and any other entry with the same thread and tag stops being committed and becomes free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request, held until granted |
| ren_tid | input | 1 | Thread of the request |
| ren_src | input | 5 | Source register index |
| ren_dst | input | 5 | Destination register index |
| ren_ok | output | 1 | Request granted this cycle |
| src_phys | output | 4 | Physical register of the source (valid with ren_ok) |
| dst_phys | output | 4 | Physical register given to the destination (valid with ren_ok) |
| bp_we | input | 1 | Base pointer write |
| bp_tid | input | 1 | Thread whose base pointer is written |
| bp_val | input | 16 | New base pointer value |
| cm_valid | input | 1 | Commit of one renamed instruction |
| cm_src | input | 4 | Physical register of the committed source |
| cm_dst | input | 4 | Physical register of the committed destination |
| flush | input | 1 | Branch-mispredict flush |
| fill_req | output | 1 | Fill outstanding |
| fill_addr | output | 16 | Memory address to fill from |
| fill_phys | output | 4 | Physical register to fill |
| fill_done | input | 1 | Transfer engine finished the fill |
| spill_req | output | 1 | One-cycle spill request |
| spill_addr | output | 16 | Memory address to spill to |
| spill_phys | output | 4 | Physical register to spill |

## Verification
`ren_ok`, `src_phys` and `dst_phys` are combinational in the request cycle, so the bench drives each request on a falling edge and reads them 1 ns later, before the rising edge. `fill_req` and `spill_req` are registered. The bench reads them at the falling edge after the allocation edge, and it counts the cycles of a deliberately delayed `fill_done` during which `ren_ok` must stay low. A fixed rename sequence fills all sixteen entries. The expected victim of every later allocation follows from an age and priority calculation made in advance, and the expected fill and spill addresses follow from plain base-plus-index arithmetic, including an alias on the truncated tag and a wrap at 2^16.

// File: rtl/regcache_rename.sv
module regcache_rename #(
  parameter int NT  = 2,
  parameter int IW  = 5,
  parameter int AW  = 16,
  parameter int TW  = 8,
  parameter int NE  = 16,
  parameter int RCW = 3,
  parameter int AGW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ren_valid,
  input  logic [((NT>1)?$clog2(NT):1)-1:0] ren_tid,
  input  logic [IW-1:0]         ren_src,
  input  logic [IW-1:0]         ren_dst,
  output logic                  ren_ok,
  output logic [$clog2(NE)-1:0] src_phys,
  output logic [$clog2(NE)-1:0] dst_phys,
  input  logic                  bp_we,
  input  logic [((NT>1)?$clog2(NT):1)-1:0] bp_tid,
  input  logic [AW-1:0]         bp_val,
  input  logic                  cm_valid,
  input  logic [$clog2(NE)-1:0] cm_src,
  input  logic [$clog2(NE)-1:0] cm_dst,
  input  logic                  flush,
  output logic                  fill_req,
  output logic [AW-1:0]         fill_addr,
  output logic [$clog2(NE)-1:0] fill_phys,
  input  logic                  fill_done,
  output logic                  spill_req,
  output logic [AW-1:0]         spill_addr,
  output logic [$clog2(NE)-1:0] spill_phys
);
  localparam int TDW = (NT > 1) ? $clog2(NT) : 1;
  localparam int PW  = $clog2(NE);

  logic [AW-1:0]  base [NT];
  logic [NE-1:0]  sv, cv, pend, dirty;
  logic [TDW-1:0] etid [NE];
  logic [TW-1:0]  etag [NE];
  logic [RCW-1:0] rc   [NE];
  logic [AGW-1:0] age  [NE];

  logic [AW-1:0] s_addr, d_addr;
  assign s_addr = base[ren_tid] + AW'(ren_src);
  assign d_addr = base[ren_tid] + AW'(ren_dst);

  logic [TW-1:0] s_tag, d_tag;
  assign s_tag = s_addr[TW-1:0];
  assign d_tag = d_addr[TW-1:0];

  logic [NE-1:0] s_match, d_match, cand, unused;
  logic [PW-1:0] s_idx, vic, vu, va;
  logic          s_any, vu_f, va_f, vic_ok;
  logic [AGW-1:0] va_age;

  always_comb begin
    s_idx = '0;
    vu = '0; vu_f = 1'b0;
    va = '0; va_f = 1'b0; va_age = '0;
    for (int i = 0; i < NE; i++) begin
      s_match[i] = sv[i] && etid[i] == ren_tid && etag[i] == s_tag;
      d_match[i] = sv[i] && etid[i] == ren_tid && etag[i] == d_tag;
      unused[i]  = !sv[i] && !cv[i];
      cand[i]    = rc[i] == '0 && !pend[i] && !(cv[i] && !sv[i]) && !s_match[i];
      if (s_match[i]) s_idx = PW'(i);
      if (cand[i]) begin
        if (unused[i]) begin
          if (!vu_f) begin vu = PW'(i); vu_f = 1'b1; end
        end else if (!va_f || age[i] > va_age) begin
          va = PW'(i); va_f = 1'b1; va_age = age[i];
        end
      end
    end
  end

  assign s_any  = |s_match;
  assign vic    = vu_f ? vu : va;
  assign vic_ok = vu_f | va_f;

  logic do_fill, grant, alloc, spill_now;
  assign do_fill   = ren_valid && !flush && !s_any && !fill_req && vic_ok;
  assign grant     = ren_valid && !flush && s_any && !pend[s_idx] && vic_ok;
  assign alloc     = do_fill || grant;
  assign spill_now = alloc && sv[vic] && dirty[vic];

  assign ren_ok   = grant;
  assign src_phys = s_idx;
  assign dst_phys = vic;

  logic [NE-1:0] cv_nx, sv_nx;
  always_comb begin
    for (int i = 0; i < NE; i++) begin
      cv_nx[i] = cv[i];
      if (fill_done && fill_req && PW'(i) == fill_phys && pend[i] && sv[i]) cv_nx[i] = 1'b1;
      if (cm_valid) begin
        if (PW'(i) == cm_dst) cv_nx[i] = 1'b1;
        else if (etid[i] == etid[cm_dst] && etag[i] == etag[cm_dst]) cv_nx[i] = 1'b0;
      end
      if (alloc && PW'(i) == vic) cv_nx[i] = 1'b0;

      sv_nx[i] = sv[i];
      if (grant && d_match[i]) sv_nx[i] = 1'b0;
      if (alloc && PW'(i) == vic) sv_nx[i] = 1'b1;
      if (flush) sv_nx[i] = cv_nx[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) base[t] <= '0;
      sv <= '0; cv <= '0; pend <= '0; dirty <= '0;
      for (int i = 0; i < NE; i++) begin
        etid[i] <= '0; etag[i] <= '0; rc[i] <= '0; age[i] <= '0;
      end
      fill_req <= 1'b0; fill_addr <= '0; fill_phys <= '0;
      spill_req <= 1'b0; spill_addr <= '0; spill_phys <= '0;
    end else begin
      if (bp_we) base[bp_tid] <= bp_val;
      sv <= sv_nx;
      cv <= cv_nx;
      for (int i = 0; i < NE; i++) begin
        if (flush) rc[i] <= '0;
        else rc[i] <= rc[i]
                    + RCW'(grant && s_idx == PW'(i)) + RCW'(grant && vic == PW'(i))
                    - RCW'(cm_valid && cm_src == PW'(i)) - RCW'(cm_valid && cm_dst == PW'(i));
        if (grant) begin
          if (PW'(i) == s_idx || PW'(i) == vic) age[i] <= '0;
          else if (age[i] != '1) age[i] <= age[i] + 1'b1;
        end else if (do_fill && PW'(i) == vic) age[i] <= '0;
        if (fill_done && fill_req && PW'(i) == fill_phys) pend[i] <= 1'b0;
        if (alloc && PW'(i) == vic) begin
          etid[i]  <= ren_tid;
          etag[i]  <= do_fill ? s_tag : d_tag;
          dirty[i] <= grant;
          pend[i]  <= do_fill;
        end
      end
      if (do_fill) begin
        fill_req  <= 1'b1;
        fill_addr <= s_addr;
        fill_phys <= vic;
      end else if (fill_done) begin
        fill_req <= 1'b0;
      end
      spill_req  <= spill_now;
      spill_addr <= {base[etid[vic]][AW-1:TW], etag[vic]};
      spill_phys <= vic;
    end
  end

  // R3
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_done |=> fill_req && $stable(fill_addr) && $stable(fill_phys));

  // R3
  fill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && ren_ok |-> src_phys != fill_phys);

  // R4
  dst_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_ok |-> dst_phys != src_phys);

  // R5
  uniq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_match));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_ok |-> rc[src_phys] != '1);

  // R7
  spill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spill_req |-> $past(ren_valid) && !$past(flush));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ren_ok || rc[src_phys] == '0);
endmodule

// File: tb/regcache_rename_tb.sv
`timescale 1ns/1ps
module regcache_rename_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic ren_valid = 0, ren_tid = 0, bp_we = 0, bp_tid = 0, cm_valid = 0, flush = 0, fill_done = 0;
  logic [4:0] ren_src = 0, ren_dst = 0;
  logic [15:0] bp_val = 0;
  logic [3:0] cm_src = 0, cm_dst = 0;
  logic ren_ok, fill_req, spill_req;
  logic [3:0] src_phys, dst_phys, fill_phys, spill_phys;
  logic [15:0] fill_addr, spill_addr;

  regcache_rename dut_i (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_tid(ren_tid),
    .ren_src(ren_src), .ren_dst(ren_dst), .ren_ok(ren_ok), .src_phys(src_phys),
    .dst_phys(dst_phys), .bp_we(bp_we), .bp_tid(bp_tid), .bp_val(bp_val),
    .cm_valid(cm_valid), .cm_src(cm_src), .cm_dst(cm_dst), .flush(flush),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_phys(fill_phys),
    .fill_done(fill_done), .spill_req(spill_req), .spill_addr(spill_addr),
    .spill_phys(spill_phys));

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int gf, fa, fp, sp, dp, nsp, spa, spp, waits;

  task automatic ren(input logic t, input int s, input int d, input int fd);
    gf = 0; nsp = 0; waits = 0; sp = -1; dp = -1; fa = -1; fp = -1; spa = -1; spp = -1;
    @(negedge clk);
    ren_valid = 1; ren_tid = t; ren_src = 5'(s); ren_dst = 5'(d);
    for (int k = 0; k < 40; k++) begin
      #1;
      if (ren_ok) begin
        sp = src_phys; dp = dst_phys;
        @(posedge clk); @(negedge clk);
        ren_valid = 0;
        if (spill_req) begin nsp++; spa = spill_addr; spp = spill_phys; end
        break;
      end
      @(posedge clk); @(negedge clk);
      if (spill_req) begin nsp++; spa = spill_addr; spp = spill_phys; end
      if (fill_req && gf == 0) begin
        gf = 1; fa = fill_addr; fp = fill_phys;
        for (int w = 0; w < fd; w++) begin
          #1; if (!ren_ok) waits++;
          @(posedge clk); @(negedge clk);
        end
        fill_done = 1;
        @(posedge clk); @(negedge clk);
        fill_done = 0;
      end
    end
    ren_valid = 0;
  endtask

  task automatic commit(input int s, input int d);
    @(negedge clk);
    cm_valid = 1; cm_src = 4'(s); cm_dst = 4'(d);
    @(posedge clk); @(negedge clk);
    cm_valid = 0;
  endtask

  task automatic setbase(input logic t, input int v);
    @(negedge clk);
    bp_we = 1; bp_tid = t; bp_val = 16'(v);
    @(posedge clk); @(negedge clk);
    bp_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int b [2];
    b[0] = 16'h0100; b[1] = 16'h0300;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 ren_ok", ren_ok, 0);
    chk("R1 fill_req", fill_req, 0);
    chk("R1 spill_req", spill_req, 0);

    setbase(0, b[0]);
    setbase(1, b[1]);

    // R1 R2 R3 R4: fill every entry, lowest index first
    for (int i = 0; i < 8; i++) begin
      ren(i[0], i, 16 + i, (i == 0) ? 3 : 1);
      chk("R3 fill seen", gf, 1);
      chk("R2 fill_addr", fa, b[i % 2] + i);
      chk("R1 fill_phys", fp, 2 * i);
      chk("R3 src_phys", sp, 2 * i);
      chk("R4 dst_phys", dp, 2 * i + 1);
      chk("R6 no spill unused", nsp, 0);
      if (i == 0) chk("R3 stall while filling", waits, 3);
      commit(sp, dp);
    end

    // R6 R7: oldest entry taken, dirty one spilled
    ren(0, 0, 20, 1);
    chk("R4 hit no fill", gf, 0);
    chk("R4 src hit", sp, 0);
    chk("R6 lru victim", dp, 1);
    chk("R7 spill count", nsp, 1);
    chk("R7 spill_addr", spa, b[0] + 16);
    chk("R7 spill_phys", spp, 1);
    commit(sp, dp);

    // R9 R6: superseded committed entry becomes unused and is preferred
    ren(1, 1, 21, 1);
    chk("R5 src hit t1", sp, 2);
    chk("R9 freed entry reused", dp, 9);
    chk("R6 no spill on unused", nsp, 0);
    commit(sp, dp);

    ren(0, 30, 31, 1);
    chk("R3 fill_addr", fa, b[0] + 30);
    chk("R6 fill into freed", fp, 11);
    chk("R6 age victim", dp, 3);
    chk("R7 spill_addr t1", spa, b[1] + 17);
    chk("R7 spill_phys", spp, 3);
    commit(sp, dp);

    ren(0, 29, 29, 1);
    chk("R6 fill victim", fp, 4);
    chk("R2 fill_addr", fa, b[0] + 29);
    chk("R7 one spill only", nsp, 1);
    chk("R7 spill_addr", spa, b[0] + 18);
    chk("R4 dst distinct", dp, 5);
    commit(sp, dp);

    // R8: speculative remap then flush
    ren(0, 30, 20, 1);
    chk("R4 src hit", sp, 11);
    chk("R6 unused victim", dp, 4);
    @(negedge clk); flush = 1;
    @(posedge clk); @(negedge clk); flush = 0;
    ren(0, 20, 30, 1);
    chk("R8 restored mapping", sp, 1);
    chk("R8 no fill after flush", gf, 0);
    chk("R8 uncommitted freed", dp, 4);
    commit(sp, dp);

    // R5: same address from other thread misses
    setbase(1, b[0]);
    ren(1, 30, 7, 1);
    chk("R5 thread miss", gf, 1);
    chk("R2 new base", fa, b[0] + 30);
    chk("R9 fill freed entry", fp, 11);
    commit(sp, dp);

    // R5: high address bits ignored
    setbase(0, 16'h0200);
    ren(0, 30, 9, 1);
    chk("R5 alias hit", gf, 0);
    chk("R5 alias phys", sp, 4);
    commit(sp, dp);

    // R2 wrap
    setbase(1, 16'hFFFE);
    ren(1, 4, 10, 1);
    chk("R2 wrap fill", gf, 1);
    chk("R2 wrap addr", fa, 2);
    commit(sp, dp);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule